// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a memory-mapped SPI master for one of four peripheral select lines. Software programs the shift clock divider, the word length, the target select line and that line's clock phase, clock polarity, select polarity and burst behaviour. It then loads up to eight words into the transmit queue and sets the exchange bit. The controller shifts each word out MSB first on `mosi`, captures `miso` into the receive queue, and clears the exchange bit by itself once the transmit queue is empty and the last word has finished.

Software reads received words from the receive data offset; each read removes one word. A level interrupt is raised while an enabled condition holds: transmit queue empty, or receive data available. The register bus is a plain single-cycle 32-bit port: writes take effect at the clock edge, and read data is combinational from the offset.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, control, config and interrupt-enable read 0, status reads 0x1 (transmit queue empty only), `irq` is 0, `sclk` is 0 and every `ss` line is high.
- R2: Offsets are fixed: 0x00 receive data, 0x04 transmit data, 0x08 control, 0x0C config, 0x10 interrupt enable, 0x18 status. The control word holds enable in bit 0, exchange in bit 2, per-line master bits in [7:4], the post-divider exponent in [11:8], the pre-divider in [15:12], the line select in [19:18] and the word length minus one in [24:20]. The config word holds, for line n, phase in bit n, polarity in bit n+4, burst in bit n+8 and select polarity in bit n+12. Control, config and interrupt enable read back what was written, with the exchange bit showing its live value.
- R3: The `sclk` period is 2·max(1, ((pre+1)·2^post)/2) system clocks, the division rounded down.
- R4: Each word is bl+1 bits long, MSB first. With phase 0, `miso` is sampled on the leading edge and `mosi` changes on the trailing edge. With phase 1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge. `sclk` rests at the selected line's polarity bit whenever no select line is active.
- R5: Only the selected line ever goes active, at the level of its select-polarity bit (1 = active high). Every other line stays at the inverse of its own polarity bit. The line goes active exactly one half-period before the first `sclk` edge and goes inactive one half-period after the last edge.
- R6: With the burst bit of the selected line set, the select stays active across all words of one exchange. With it clear, the select is released between words.
- R7: Writing control with bit 0 and bit 2 both set starts an exchange. The exchange bit reads 1 until the transmit queue is empty and the last word is done, then clears by itself. A write with bit 0 clear leaves the exchange bit at 0 and starts nothing.
- R8: The transmit queue holds 8 words. A write to it while full is ignored. Status bit 2 shows full, and status bit 0 shows empty.
- R9: A read of offset 0x00 pops one received word. Status bit 3 is 1 while at least one word is held. When the 8-word receive queue is full, a newly received word is dropped.
- R10: `irq` = (enable bit 0 AND transmit empty) OR (enable bit 3 AND receive ready), as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data at offset 0x00) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 4 | Select lines, polarity per line |

## Verification
The bench runs exchanges in all four phase/polarity combinations, with word lengths of 5, 8, 16 and 32 bits and different select lines. A wrong sampling edge, a wrong bit order or a wrong length therefore shows up as a data mismatch in one mode and not in the others. The dividers are chosen so the measured period separates the linear stage from the power-of-two stage and checks the rounding at the smallest divisor. Burst and non-burst runs differ only in how many times the select line goes active. The queue-limit runs push ten words into an eight-word queue, and fill the receive side before a second exchange, so a dropped word and an overwritten word can be told apart.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int NCS    = 4;
  localparam int CS_W   = $clog2(NCS);
  localparam int DW     = 32;
  localparam int BL_W   = $clog2(DW);
  localparam int DIV_W  = 4;
  localparam int HALF_W = 20;
  localparam int AW     = 5;

  localparam logic [AW-1:0] OFS_RX   = 5'h00;
  localparam logic [AW-1:0] OFS_TX   = 5'h04;
  localparam logic [AW-1:0] OFS_CTRL = 5'h08;
  localparam logic [AW-1:0] OFS_CFG  = 5'h0C;
  localparam logic [AW-1:0] OFS_IE   = 5'h10;
  localparam logic [AW-1:0] OFS_STAT = 5'h18;

  localparam int C_EN = 0, C_XCH = 2, C_MST = 4, C_POST = 8, C_PRE = 12, C_CS = 18, C_BL = 20;
  localparam int G_PHA = 0, G_POL = 4, G_BURST = 8, G_SSPOL = 12;
  localparam int IE_TX = 0, IE_RX = 3;
  localparam int S_TXE = 0, S_TXF = 2, S_RXR = 3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_TRAIL, ENG_GAP} eng_state_t;

  // half period in system clocks: floor((pre+1)*2^post / 2), at least 1
  function automatic logic [HALF_W-1:0] sclk_half(input logic [DIV_W-1:0] pre,
                                                   input logic [DIV_W-1:0] post);
    logic [HALF_W-1:0] full;
    logic [HALF_W-1:0] half;
    full = (HALF_W'(pre) + HALF_W'(1)) << post;
    half = full >> 1;
    if (half == '0) half = HALF_W'(1);
    return half;
  endfunction
endpackage

// File: rtl/spi_master_fifo.sv
module spi_master_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/spi_master_tick.sv
module spi_master_tick
  import spi_master_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_master_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic            pha,
  input  logic            pol,
  input  logic            burst,
  input  logic [BL_W-1:0] bl,
  input  logic            tx_empty,
  input  logic [DW-1:0]   tx_data,
  input  logic            miso,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [DW-1:0]   rx_data,
  output logic            done,
  output logic            busy,
  output logic            ss_act,
  output logic            sclk,
  output logic            mosi
);
  eng_state_t      st;
  logic [DW-1:0]   sh, rxsh;
  logic [BL_W:0]   edge_n;
  logic            sclk_q, mosi_q;
  logic            last, lead, samp, drive;
  logic            st_idle, st_shift, st_trail, st_gap;

  assign st_idle  = (st == ENG_IDLE);
  assign st_shift = (st == ENG_SHIFT);
  assign st_trail = (st == ENG_TRAIL);
  assign st_gap   = (st == ENG_GAP);

  assign last  = (edge_n == {bl, 1'b1});
  assign lead  = !edge_n[0];
  assign samp  = lead ^ pha;
  assign drive = !samp && !(last && !pha);

  assign tx_pop  = !tx_empty && ((st_idle && start) ||
                                 (st_trail && tick && burst) ||
                                 (st_gap && tick));
  assign done    = tx_empty && ((st_idle && start) || ((st_trail || st_gap) && tick));
  assign rx_push = st_shift && tick && last;
  assign rx_data = pha ? {rxsh[DW-2:0], miso} : rxsh;
  assign busy    = !st_idle;
  assign ss_act  = st_shift || st_trail;
  assign sclk    = busy ? sclk_q : pol;
  assign mosi    = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      sh     <= '0;
      rxsh   <= '0;
      edge_n <= '0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
    end else if (tx_pop) begin
      st     <= ENG_SHIFT;
      sh     <= pha ? tx_data : (tx_data << 1);
      if (!pha) mosi_q <= tx_data[bl];
      rxsh   <= '0;
      edge_n <= '0;
      sclk_q <= pol;
    end else begin
      unique case (st)
        ENG_IDLE: sclk_q <= pol;
        ENG_SHIFT: if (tick) begin
          sclk_q <= !sclk_q;
          edge_n <= edge_n + 1'b1;
          if (samp) rxsh <= {rxsh[DW-2:0], miso};
          if (drive) begin
            mosi_q <= sh[bl];
            sh     <= sh << 1;
          end
          if (last) st <= ENG_TRAIL;
        end
        ENG_TRAIL: if (tick) st <= tx_empty ? ENG_IDLE : ENG_GAP;
        ENG_GAP:   if (tick) st <= ENG_IDLE;
        default:   st <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] ss
);
  logic             ctl_en, ctl_xch;
  logic [NCS-1:0]   ctl_mst;
  logic [DIV_W-1:0] ctl_post, ctl_pre;
  logic [CS_W-1:0]  ctl_cs;
  logic [BL_W-1:0]  ctl_bl;
  logic [NCS-1:0]   cfg_pha, cfg_pol, cfg_burst, cfg_sspol;
  logic             ie_tx, ie_rx;

  logic             wr_tx, wr_ctrl, wr_cfg, wr_ie;
  logic             tx_push, tx_pop, tx_empty, tx_full;
  logic             rx_push, rx_pop, rx_empty, rx_full, rx_ready;
  logic [CW-1:0]    tx_count, rx_count;
  logic [DW-1:0]    tx_head, rx_head, rx_word;
  logic             tick, busy, done, ss_act;
  logic             sel_pha, sel_pol, sel_burst;
  logic [HALF_W-1:0] half;
  logic             unused_ok;

  assign wr_tx   = bus_wr && (bus_addr == OFS_TX);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
  assign wr_ie   = bus_wr && (bus_addr == OFS_IE);
  assign tx_push = wr_tx;
  assign rx_pop  = bus_rd && (bus_addr == OFS_RX);
  assign rx_ready = !rx_empty;

  assign sel_pha   = cfg_pha[ctl_cs];
  assign sel_pol   = cfg_pol[ctl_cs];
  assign sel_burst = cfg_burst[ctl_cs];
  assign half      = sclk_half(ctl_pre, ctl_post);
  assign irq       = (ie_tx && tx_empty) || (ie_rx && rx_ready);

  assign unused_ok = ^{bus_wdata[1], bus_wdata[3], bus_wdata[17:16], bus_wdata[31:25],
                       bus_wdata[31:16], bus_wdata[2:1], tx_count, rx_count, tx_full, rx_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_xch <= 1'b0; ctl_mst <= '0;
      ctl_post <= '0; ctl_pre <= '0; ctl_cs <= '0; ctl_bl <= '0;
      cfg_pha <= '0; cfg_pol <= '0; cfg_burst <= '0; cfg_sspol <= '0;
      ie_tx <= 1'b0; ie_rx <= 1'b0;
    end else begin
      if (done) ctl_xch <= 1'b0;
      if (wr_ctrl) begin
        ctl_en   <= bus_wdata[C_EN];
        if (!bus_wdata[C_EN])                      ctl_xch <= 1'b0;
        else if (bus_wdata[C_XCH])                 ctl_xch <= 1'b1;
        ctl_mst  <= bus_wdata[C_MST  +: NCS];
        ctl_post <= bus_wdata[C_POST +: DIV_W];
        ctl_pre  <= bus_wdata[C_PRE  +: DIV_W];
        ctl_cs   <= bus_wdata[C_CS   +: CS_W];
        ctl_bl   <= bus_wdata[C_BL   +: BL_W];
      end
      if (wr_cfg) begin
        cfg_pha   <= bus_wdata[G_PHA   +: NCS];
        cfg_pol   <= bus_wdata[G_POL   +: NCS];
        cfg_burst <= bus_wdata[G_BURST +: NCS];
        cfg_sspol <= bus_wdata[G_SSPOL +: NCS];
      end
      if (wr_ie) begin
        ie_tx <= bus_wdata[IE_TX];
        ie_rx <= bus_wdata[IE_RX];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_RX:   bus_rdata = rx_head;
      OFS_CTRL: begin
        bus_rdata[C_EN]              = ctl_en;
        bus_rdata[C_XCH]             = ctl_xch;
        bus_rdata[C_MST  +: NCS]     = ctl_mst;
        bus_rdata[C_POST +: DIV_W]   = ctl_post;
        bus_rdata[C_PRE  +: DIV_W]   = ctl_pre;
        bus_rdata[C_CS   +: CS_W]    = ctl_cs;
        bus_rdata[C_BL   +: BL_W]    = ctl_bl;
      end
      OFS_CFG: begin
        bus_rdata[G_PHA   +: NCS] = cfg_pha;
        bus_rdata[G_POL   +: NCS] = cfg_pol;
        bus_rdata[G_BURST +: NCS] = cfg_burst;
        bus_rdata[G_SSPOL +: NCS] = cfg_sspol;
      end
      OFS_IE: begin
        bus_rdata[IE_TX] = ie_tx;
        bus_rdata[IE_RX] = ie_rx;
      end
      OFS_STAT: begin
        bus_rdata[S_TXE] = tx_empty;
        bus_rdata[S_TXF] = tx_full;
        bus_rdata[S_RXR] = rx_ready;
      end
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NCS; i++) begin : g_ss
    assign ss[i] = (ss_act && (ctl_cs == CS_W'(i))) ? cfg_sspol[i] : !cfg_sspol[i];
  end

  spi_master_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_count));

  spi_master_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_count));

  spi_master_tick u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick));

  spi_master_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(ctl_en && ctl_xch), .tick(tick),
    .pha(sel_pha), .pol(sel_pol), .burst(sel_burst), .bl(ctl_bl),
    .tx_empty(tx_empty), .tx_data(tx_head), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word), .done(done),
    .busy(busy), .ss_act(ss_act), .sclk(sclk), .mosi(mosi));
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk
  import spi_master_pkg::*;
#(
  parameter int CW = 4,
  parameter int DEPTH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] ss,
  input logic [NCS-1:0] sspol,
  input logic           sclk,
  input logic           sel_pol,
  input logic           busy,
  input logic           tick,
  input logic           tx_push,
  input logic           tx_pop,
  input logic           tx_full,
  input logic [CW-1:0]  tx_count,
  input logic           rx_push,
  input logic           rx_pop,
  input logic           rx_full,
  input logic [CW-1:0]  rx_count,
  input logic           xch,
  input logic           irq,
  input logic           ie_tx,
  input logic           ie_rx
);
  logic [NCS-1:0] active;
  assign active = ss ~^ sspol;

  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active));

  p_sclk_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> (sclk == sel_pol));

  p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sclk)) |-> $past(tick));

  p_tx_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_pop) |=> (tx_count == CW'(DEPTH)));

  p_rx_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_pop) |=> (rx_count == CW'(DEPTH)));

  p_xch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch) |-> (tx_count == '0 && !busy));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ie_tx && tx_count == '0) || (ie_rx && rx_count != '0)));
endmodule

bind spi_master_regs spi_master_regs_chk #(.CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss(ss), .sspol(cfg_sspol), .sclk(sclk),
  .sel_pol(sel_pol), .busy(busy), .tick(tick),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full), .tx_count(tx_count),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .rx_count(rx_count),
  .xch(ctl_xch), .irq(irq), .ie_tx(ie_tx), .ie_rx(ie_rx));

// File: tb/spi_master_regs_tb.sv
module spi_master_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  ss;

  always #5 clk = ~clk;

  spi_master_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss(ss));

  int n_chk = 0, n_pass = 0;

  // bench-side view of the configuration
  int   b_cs = 0, b_bits = 8, arm_cnt = 0;
  logic b_pha = 0, b_pol = 0, b_sspol = 0, chk_on = 0;
  logic [3:0] b_sspolv = '0;

  // behavioural slave state
  logic [31:0] got[$];
  int   widx = 0, edges = 0, arm_seen = 0, cyc = 0;
  int   ss_rises = 0, rise_cyc = 0, first_lead = -1, trail = -1;
  int   last_edge_cyc = 0, prev_lead_cyc = 0, last_period = 0, inv_err = 0;
  logic have_lead = 0, lead_pend = 0, prev_act = 0, prev_sclk = 0;
  logic [31:0] sresp = '0, rxw = '0;

  function automatic logic [31:0] resp(int k);
    return 32'h3C5A_96E1 ^ (32'(k) * 32'h0101_0F0B);
  endfunction
  function automatic logic [31:0] msk(int bits);
    return (bits >= 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 1);
  endfunction

  always @(negedge clk) begin
    logic act, lead_e;
    cyc++;
    if (arm_cnt != arm_seen) begin
      arm_seen = arm_cnt; edges = 0; rxw = '0; sresp = resp(widx);
      if (!b_pha) begin miso = sresp[b_bits-1]; sresp = sresp << 1; end
      ss_rises = 0; first_lead = -1; trail = -1; last_period = 0; have_lead = 0;
    end
    act = (ss[b_cs] == b_sspol);
    if (act && !prev_act) begin ss_rises++; rise_cyc = cyc; lead_pend = 1; end
    if (!act && prev_act) trail = cyc - last_edge_cyc;
    if (act && sclk != prev_sclk) begin
      lead_e = (sclk != b_pol);
      if (lead_pend) begin first_lead = cyc - rise_cyc; lead_pend = 0; end
      if (lead_e) begin
        if (have_lead) last_period = cyc - prev_lead_cyc;
        prev_lead_cyc = cyc; have_lead = 1;
      end
      last_edge_cyc = cyc;
      edges++;
      if (lead_e ^ b_pha) rxw = (rxw << 1) | 32'(mosi);
      else if (edges != 2 * b_bits) begin miso = sresp[b_bits-1]; sresp = sresp << 1; end
      if (edges == 2 * b_bits) begin
        got.push_back(rxw); widx++; edges = 0; rxw = '0; sresp = resp(widx);
        have_lead = 0;
        if (!b_pha) begin miso = sresp[b_bits-1]; sresp = sresp << 1; end
      end
    end
    if (chk_on) begin
      for (int i = 0; i < 4; i++)
        if (i != b_cs && ss[i] != !b_sspolv[i]) inv_err++;
      if (!act && sclk != b_pol) inv_err++;
    end
    prev_act = act; prev_sclk = sclk;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act === exp) n_pass++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(bit en, bit x, int cs, int bits, int pre, int post);
    return 32'(en) | (32'(x) << 2) | (32'hF << 4) | (32'(post) << 8) | (32'(pre) << 12) |
           (32'(cs) << 18) | (32'(bits - 1) << 20);
  endfunction

  task automatic setup(int cs, bit pha, bit pol, bit burst, bit sp, int bits, int pre, int post);
    chk_on = 0;
    b_cs = cs; b_pha = pha; b_pol = pol; b_sspol = sp; b_bits = bits;
    b_sspolv = '0; b_sspolv[cs] = sp;
    wr(5'h0C, (32'(pha) << cs) | (32'(pol) << (cs + 4)) | (32'(burst) << (cs + 8)) |
              (32'(sp) << (cs + 12)));
    wr(5'h08, mk_ctrl(1, 0, cs, bits, pre, post));
    arm_cnt++;
    repeat (2) @(negedge clk);
    chk_on = 1;
  endtask

  task automatic go(int cs, int bits, int pre, int post);
    logic [31:0] v;
    wr(5'h08, mk_ctrl(1, 1, cs, bits, pre, post));
    for (int k = 0; k < 20000; k++) begin
      rd(5'h08, v);
      if (!v[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // one exchange of n words; checks data both ways
  task automatic xfer(string tag, int cs, bit pha, bit pol, bit burst, bit sp, int bits,
                      int pre, int post, int n);
    logic [31:0] v, tx[$];
    int base;
    setup(cs, pha, pol, burst, sp, bits, pre, post);
    base = got.size();
    for (int k = 0; k < n; k++) begin
      tx.push_back(32'hC3A5_5A3C ^ (32'(k) * 32'h1357_9BDF) ^ 32'(bits));
      wr(5'h04, tx[k]);
    end
    go(cs, bits, pre, post);
    check({tag, " R4 words shifted"}, 32'(got.size() - base), 32'(n));
    for (int k = 0; k < n; k++) begin
      check({tag, " R4 mosi word"}, (got.size() > base + k) ? got[base + k] : 32'hX,
            tx[k] & msk(bits));
      rd(5'h00, v);
      check({tag, " R4 miso word"}, v, resp(base + k) & msk(bits));
    end
    rd(5'h18, v);
    check({tag, " R9 rx drained"}, 32'(v[3]), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h08, v); check("R1 ctrl", v, 32'h0);
    rd(5'h0C, v); check("R1 cfg", v, 32'h0);
    rd(5'h10, v); check("R1 ie", v, 32'h0);
    rd(5'h18, v); check("R1 status", v, 32'h1);
    check("R1 irq/sclk/ss", {26'd0, irq, sclk, ss}, {26'd0, 1'b0, 1'b0, 4'hF});
    // R2 readback
    wr(5'h08, 32'h0074_21F1); rd(5'h08, v); check("R2 ctrl readback", v, 32'h0074_21F1);
    wr(5'h0C, 32'h0000_ABCD); rd(5'h0C, v); check("R2 cfg readback", v, 32'h0000_ABCD);
    wr(5'h10, 32'h9);         rd(5'h10, v); check("R2 ie readback", v, 32'h9);
    // R10 levels with empty queues
    wr(5'h10, 32'h1); @(negedge clk); check("R10 irq tx empty", 32'(irq), 32'd1);
    wr(5'h10, 32'h8); @(negedge clk); check("R10 irq rx idle", 32'(irq), 32'd0);

    // mode 0, 8 bit, line 0, smallest divider, no burst
    setup(0, 0, 0, 0, 0, 8, 0, 0);
    base = got.size();
    for (int k = 0; k < 3; k++) wr(5'h04, 32'h100 + 32'(k * 37));
    go(0, 8, 0, 0);
    rd(5'h08, v); check("R7 xch self clear", 32'(v[2]), 32'd0);
    rd(5'h18, v); check("R9 rx ready", 32'(v[3]), 32'd1);
    check("R10 irq rx ready", 32'(irq), 32'd1);
    check("R6 select per word", 32'(ss_rises), 32'd3);
    check("R3 period pre0 post0", 32'(last_period), 32'd2);
    check("R5 lead half", 32'(first_lead), 32'd1);
    check("R5 trail half", 32'(trail), 32'd1);
    for (int k = 0; k < 3; k++) begin
      check("R4 mode0 mosi", got[base + k], (32'h100 + 32'(k * 37)) & 32'hFF);
      rd(5'h00, v); check("R4 mode0 miso", v, resp(base + k) & 32'hFF);
    end
    rd(5'h18, v); check("R9 drained", 32'(v[3]), 32'd0);
    check("R10 irq drops", 32'(irq), 32'd0);

    // mode 3, 16 bit, line 2, active-high select, burst
    xfer("m3", 2, 1, 1, 1, 1, 16, 2, 1, 4);
    check("R6 burst one select", 32'(ss_rises), 32'd1);
    check("R3 period pre2 post1", 32'(last_period), 32'd6);
    check("R5 lead pre2 post1", 32'(first_lead), 32'd3);
    check("R5 trail pre2 post1", 32'(trail), 32'd3);
    // mode 1, 32 bit, line 3
    xfer("m1", 3, 1, 0, 0, 0, 32, 3, 0, 2);
    check("R3 period pre3 post0", 32'(last_period), 32'd4);
    // mode 2, 5 bit, line 1
    xfer("m2", 1, 0, 1, 0, 0, 5, 0, 2, 3);
    check("R3 period pre0 post2", 32'(last_period), 32'd4);
    check("R6 select per word m2", 32'(ss_rises), 32'd3);

    // R8: ten writes into the 8-word transmit queue
    setup(0, 0, 0, 0, 0, 8, 0, 0);
    base = got.size();
    for (int k = 0; k < 10; k++) wr(5'h04, 32'(k + 1));
    rd(5'h18, v); check("R8 tx full flag", 32'(v[2]), 32'd1);
    go(0, 8, 0, 0);
    check("R8 only eight sent", 32'(got.size() - base), 32'd8);
    check("R8 eighth word", got[base + 7], 32'd8);
    // R9: receive queue full, two more words must be dropped
    wr(5'h04, 32'h55); wr(5'h04, 32'h66);
    go(0, 8, 0, 0);
    for (int k = 0; k < 8; k++) begin
      rd(5'h00, v); check("R9 kept oldest", v, resp(base + k) & 32'hFF);
    end
    rd(5'h18, v); check("R9 overflow dropped", 32'(v[3]), 32'd0);

    // R7: exchange request with enable clear does nothing
    base = got.size();
    wr(5'h04, 32'h77);
    wr(5'h08, mk_ctrl(0, 1, 0, 8, 0, 0));
    repeat (40) @(negedge clk);
    rd(5'h08, v); check("R7 no start when disabled", 32'(v[2]), 32'd0);
    check("R7 nothing shifted", 32'(got.size() - base), 32'd0);
    rd(5'h18, v); check("R7 tx still held", 32'(v[0]), 32'd0);
    setup(0, 0, 0, 0, 0, 8, 0, 0);
    go(0, 8, 0, 0);
    check("R7 later exchange", got[base], 32'h77);
    rd(5'h00, v);

    check("R5 per-clock select/idle compare", 32'(inv_err), 32'd0);
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule